// File: doc/BRIEF.md
# Super I/O configuration port controller

This block is the configuration front end of a legacy-style Super I/O device on a byte-wide I/O bus. It decodes two neighbouring I/O addresses: a lower one that takes register indices and unlock keys, and an upper one that carries register data. Configuration registers are hidden until the correct entry key is written twice in a row to the index port. A separate exit key hides them again.

While configuration is open, software writes a register index to the index port and then reads or writes the value at the data port. One index picks the active logical device. The other registers are banked by that device number: a UART bank holds the UART enable bit and a watchdog bank holds the watchdog timeout. The block drives the UART enable level, the timeout byte and a watchdog enable level straight from these registers. Both devices start out enabled after reset.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset `uart_en` is 1, `wdog_timeout` is 0x0A, `wdog_en` is 1, `bus_rdata` is 0xFF and configuration is closed.
- R2: Configuration opens only after 0x87 is written to the index port (0x4E) on two consecutive index-port writes. Any other byte written to the index port while closed restarts the match. Writes to other addresses do not break the sequence.
- R3: While configuration is closed, writes to the data port (0x4F) change no register, and reads from either port return 0xFF.
- R4: While configuration is open, writing 0xAA to the index port closes it. After that, one more double 0x87 is needed to reopen.
- R5: While open, any other index-port write loads the index, and a read of the index port returns it. Index 0x07 is the device select. A data write there stores the device number, and a data read returns it whatever the device is.
- R6: With device 0x02 selected, index 0x30 is the UART enable. Data bit 0 drives `uart_en`, and reads return 0x00 or 0x01.
- R7: With device 0x08 selected, index 0xF1 is the watchdog timeout. The full byte drives `wdog_timeout`. `wdog_en` is high exactly when the timeout is nonzero, so writing 0x00 disables the watchdog.
- R8: Unimplemented indices, and the 0x30 or 0xF1 index under any other device, read as 0x00 at the data port, and writes to them have no effect.
- R9: Read data is registered. It takes its new value on the clock edge that samples `bus_rd` and holds it until the next read.
- R10: Accesses to addresses other than 0x4E and 0x4F change no state, and reads of them return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 8 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| uart_en | output | 1 | UART enable level |
| wdog_timeout | output | 8 | Watchdog timeout value |
| wdog_en | output | 1 | Watchdog enable, high when timeout is nonzero |

## Verification
A write strobe sampled on one rising edge updates the register bank on that edge. `uart_en`, `wdog_timeout` and `wdog_en` show the new value straight after that edge, with no added delay. A read strobe sampled on an edge loads `bus_rdata` on that same edge. The bench drives each strobe for exactly one cycle starting at a falling edge. It samples the outputs at the next falling edge, half a cycle after the edge that took the strobe. For the hold rule, it samples `bus_rdata` again after idle and write cycles. A reference model steps with each bus operation and provides the expected values for both the random and the directed sequences.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    // Which configuration port a bus address hits
    typedef enum logic [1:0] {
        PORT_NONE  = 2'd0,
        PORT_INDEX = 2'd1,
        PORT_DATA  = 2'd2
    } port_e;

    // Which register the current index/device pair reaches
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LDN  = 2'd1,
        SEL_UART = 2'd2,
        SEL_WDT  = 2'd3
    } sel_e;

    function automatic port_e port_of(input logic [7:0] addr,
                                      input logic [7:0] base);
        port_e p;
        if (addr == base)
            p = PORT_INDEX;
        else if (addr == base + 8'd1)
            p = PORT_DATA;
        else
            p = PORT_NONE;
        return p;
    endfunction

endpackage

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock #(
    parameter int          DW        = 8,
    parameter logic [DW-1:0] KEY_ENTER = 8'h87,
    parameter logic [DW-1:0] KEY_EXIT  = 8'hAA,
    parameter int          KEY_COUNT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic [DW-1:0] wdata,
    output logic          cfg_open,
    output logic          idx_load
);

    localparam int CW = $clog2(KEY_COUNT + 1);
    localparam logic [CW-1:0] LAST = CW'(KEY_COUNT - 1);

    typedef struct packed {
        logic          open;
        logic [CW-1:0] cnt;
    } lock_t;

    lock_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        idx_load = 1'b0;
        if (idx_wr) begin
            if (!st_q.open) begin
                if (wdata == KEY_ENTER) begin
                    if (st_q.cnt == LAST) begin
                        st_d.open = 1'b1;
                        st_d.cnt  = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + CW'(1);
                    end
                end else begin
                    st_d.cnt = '0;
                end
            end else begin
                if (wdata == KEY_EXIT) begin
                    st_d.open = 1'b0;
                    st_d.cnt  = '0;
                end else begin
                    idx_load = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.open <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_open = st_q.open;

endmodule

// File: rtl/sio_cfg_regbank.sv
module sio_cfg_regbank
    import sio_cfg_pkg::*;
#(
    parameter int            DW          = 8,
    parameter logic [DW-1:0] LDN_IDX     = 8'h07,
    parameter logic [DW-1:0] UART_LDN    = 8'h02,
    parameter logic [DW-1:0] UART_EN_IDX = 8'h30,
    parameter logic [DW-1:0] WDT_LDN     = 8'h08,
    parameter logic [DW-1:0] WDT_TO_IDX  = 8'hF1,
    parameter logic          UART_RST    = 1'b1,
    parameter logic [DW-1:0] WDT_RST     = 8'h0A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_load,
    input  logic          data_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cur_idx,
    output logic [DW-1:0] cur_ldn,
    output logic [DW-1:0] reg_rdata,
    output logic          uart_en,
    output logic [DW-1:0] wdog_timeout
);

    typedef struct packed {
        logic [DW-1:0] idx;
        logic [DW-1:0] ldn;
        logic          uart;
        logic [DW-1:0] wdt;
    } bank_t;

    bank_t st_d, st_q;
    sel_e  sel;

    // Resolve index and device number to one register
    always_comb begin
        if (st_q.idx == LDN_IDX)
            sel = SEL_LDN;
        else if (st_q.idx == UART_EN_IDX && st_q.ldn == UART_LDN)
            sel = SEL_UART;
        else if (st_q.idx == WDT_TO_IDX && st_q.ldn == WDT_LDN)
            sel = SEL_WDT;
        else
            sel = SEL_NONE;
    end

    always_comb begin
        st_d = st_q;
        if (idx_load)
            st_d.idx = wdata;
        if (data_wr) begin
            unique case (sel)
                SEL_LDN:  st_d.ldn  = wdata;
                SEL_UART: st_d.uart = wdata[0];
                SEL_WDT:  st_d.wdt  = wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_LDN:  reg_rdata = st_q.ldn;
            SEL_UART: reg_rdata = {{(DW-1){1'b0}}, st_q.uart};
            SEL_WDT:  reg_rdata = st_q.wdt;
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx  <= '0;
            st_q.ldn  <= '0;
            st_q.uart <= UART_RST;
            st_q.wdt  <= WDT_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_idx      = st_q.idx;
    assign cur_ldn      = st_q.ldn;
    assign uart_en      = st_q.uart;
    assign wdog_timeout = st_q.wdt;

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] BASE_ADDR = 8'h4E,
    parameter logic [7:0] KEY_ENTER = 8'h87,
    parameter logic [7:0] KEY_EXIT  = 8'hAA,
    parameter int         KEY_COUNT = 2,
    parameter logic [7:0] IDLE_READ = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       uart_en,
    output logic [7:0] wdog_timeout,
    output logic       wdog_en
);

    typedef struct packed {
        logic [7:0] rdata;
    } rd_t;

    port_e      port;
    logic       cfg_open;
    logic       idx_load;
    logic       idx_wr;
    logic       data_wr;
    logic [7:0] cur_idx;
    logic [7:0] cur_ldn;
    logic [7:0] reg_rdata;
    rd_t        st_d, st_q;

    assign port    = port_of(bus_addr, BASE_ADDR);
    assign idx_wr  = bus_wr && (port == PORT_INDEX);
    assign data_wr = bus_wr && (port == PORT_DATA) && cfg_open;

    sio_cfg_unlock #(
        .DW        (8),
        .KEY_ENTER (KEY_ENTER),
        .KEY_EXIT  (KEY_EXIT),
        .KEY_COUNT (KEY_COUNT)
    ) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (bus_wdata),
        .cfg_open (cfg_open),
        .idx_load (idx_load)
    );

    sio_cfg_regbank #(
        .DW (8)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .idx_load     (idx_load),
        .data_wr      (data_wr),
        .wdata        (bus_wdata),
        .cur_idx      (cur_idx),
        .cur_ldn      (cur_ldn),
        .reg_rdata    (reg_rdata),
        .uart_en      (uart_en),
        .wdog_timeout (wdog_timeout)
    );

    always_comb begin
        st_d = st_q;
        if (bus_rd) begin
            if (cfg_open && port == PORT_INDEX)
                st_d.rdata = cur_idx;
            else if (cfg_open && port == PORT_DATA)
                st_d.rdata = reg_rdata;
            else
                st_d.rdata = IDLE_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q.rdata <= IDLE_READ;
        else
            st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign wdog_en   = |wdog_timeout;

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
    parameter logic [7:0] BASE_ADDR = 8'h4E,
    parameter logic [7:0] KEY_ENTER = 8'h87,
    parameter logic [7:0] KEY_EXIT  = 8'hAA
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       uart_en,
    input logic [7:0] wdog_timeout,
    input logic       cfg_open,
    input logic [7:0] cur_idx,
    input logic [7:0] cur_ldn
);

    localparam logic [7:0] DATA_ADDR = BASE_ADDR + 8'd1;

    // R2
    open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(bus_wr && bus_addr == BASE_ADDR && bus_wdata == KEY_ENTER));

    // R3
    locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_wr && bus_addr == DATA_ADDR) |=> ($stable(wdog_timeout) && $stable(uart_en)));

    // R3
    locked_read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_rd) |=> (bus_rdata == 8'hFF));

    // R4
    exit_key_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_wr && bus_addr == BASE_ADDR && bus_wdata == KEY_EXIT) |=> !cfg_open);

    // R7
    wdt_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_wr && bus_addr == DATA_ADDR && cur_idx == 8'hF1 && cur_ldn == 8'h08)
        |=> (wdog_timeout == $past(bus_wdata)));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R10
    foreign_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != BASE_ADDR && bus_addr != DATA_ADDR)
        |=> ($stable(cfg_open) && $stable(cur_idx) && $stable(wdog_timeout) && $stable(uart_en)));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
    .BASE_ADDR (BASE_ADDR),
    .KEY_ENTER (KEY_ENTER),
    .KEY_EXIT  (KEY_EXIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .uart_en      (uart_en),
    .wdog_timeout (wdog_timeout),
    .cfg_open     (cfg_open),
    .cur_idx      (cur_idx),
    .cur_ldn      (cur_ldn)
);

// File: tb/sio_cfg_port_tb.sv
`timescale 1ns/1ps
module sio_cfg_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       uart_en;
    logic [7:0] wdog_timeout;
    logic       wdog_en;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic       m_open = 1'b0;
    int         m_cnt = 0;
    logic [7:0] m_idx = 8'h00;
    logic [7:0] m_ldn = 8'h00;
    logic       m_uart = 1'b1;
    logic [7:0] m_wdt = 8'h0A;
    logic [7:0] m_rd = 8'hFF;

    always #4 clk = ~clk;

    sio_cfg_port u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .uart_en      (uart_en),
        .wdog_timeout (wdog_timeout),
        .wdog_en      (wdog_en)
    );

    function automatic void m_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h4E) begin
            if (!m_open) begin
                if (d == 8'h87) begin
                    if (m_cnt == 1) begin m_open = 1'b1; m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end else m_cnt = 0;
            end else if (d == 8'hAA) begin
                m_open = 1'b0; m_cnt = 0;
            end else m_idx = d;
        end else if (a == 8'h4F && m_open) begin
            if (m_idx == 8'h07) m_ldn = d;
            else if (m_idx == 8'h30 && m_ldn == 8'h02) m_uart = d[0];
            else if (m_idx == 8'hF1 && m_ldn == 8'h08) m_wdt = d;
        end
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] a);
        if (m_open && a == 8'h4E) return m_idx;
        if (m_open && a == 8'h4F) begin
            if (m_idx == 8'h07) return m_ldn;
            if (m_idx == 8'h30 && m_ldn == 8'h02) return {7'b0, m_uart};
            if (m_idx == 8'hF1 && m_ldn == 8'h08) return m_wdt;
            return 8'h00;
        end
        return 8'hFF;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_outs(input string tag);
        chk(uart_en == m_uart, {tag, " uart_en"}, uart_en, m_uart);
        chk(wdog_timeout == m_wdt, {tag, " wdog_timeout"}, wdog_timeout, m_wdt);
        chk(wdog_en == (m_wdt != 8'h00), {tag, " wdog_en"}, wdog_en, m_wdt != 8'h00);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        m_write(a, d);
    endtask

    task automatic rd_chk(input logic [7:0] a, input string tag);
        logic [7:0] e;
        e = m_read(a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        m_rd = e;
        chk(bus_rdata == e, tag, bus_rdata, e);
    endtask

    task automatic unlock();
        wr(8'h4E, 8'h87);
        wr(8'h4E, 8'h87);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(uart_en == 1'b1, "R1 uart_en", uart_en, 1);
        chk(wdog_timeout == 8'h0A, "R1 wdog_timeout", wdog_timeout, 8'h0A);
        chk(wdog_en == 1'b1, "R1 wdog_en", wdog_en, 1);
        chk(bus_rdata == 8'hFF, "R1 rdata", bus_rdata, 8'hFF);
        rd_chk(8'h4F, "R1 closed at reset");

        // R3 locked data write ignored, reads 0xFF
        wr(8'h4E, 8'hF1);
        wr(8'h4F, 8'h00);
        chk_outs("R3 locked write");
        rd_chk(8'h4E, "R3 locked index read");

        // R2 broken sequence does not open
        wr(8'h4E, 8'h87);
        wr(8'h4E, 8'h07);
        wr(8'h4E, 8'h87);
        rd_chk(8'h4F, "R2 broken key");
        wr(8'h4E, 8'h87);
        rd_chk(8'h4E, "R2 open after second key");

        // R5 device select
        wr(8'h4E, 8'h07);
        wr(8'h4F, 8'h08);
        rd_chk(8'h4F, "R5 ldn readback");
        rd_chk(8'h4E, "R5 index readback");

        // R7 disable watchdog
        wr(8'h4E, 8'hF1);
        rd_chk(8'h4F, "R7 wdt reset value");
        wr(8'h4F, 8'h00);
        chk(wdog_en == 1'b0, "R7 wdog_en off", wdog_en, 0);
        chk_outs("R7 after zero");
        wr(8'h4F, 8'h3C);
        chk_outs("R7 new timeout");

        // R8 unknown index and wrong bank
        wr(8'h4E, 8'h30);
        rd_chk(8'h4F, "R8 uart idx in wdt bank");
        wr(8'h4F, 8'h00);
        chk_outs("R8 wrong bank write");
        wr(8'h4E, 8'h55);
        wr(8'h4F, 8'h99);
        rd_chk(8'h4F, "R8 unimplemented idx");
        chk_outs("R8 unimplemented write");

        // R6 uart enable
        wr(8'h4E, 8'h07);
        wr(8'h4F, 8'h02);
        wr(8'h4E, 8'h30);
        wr(8'h4F, 8'hFE);
        chk(uart_en == 1'b0, "R6 uart off", uart_en, 0);
        rd_chk(8'h4F, "R6 uart readback");
        wr(8'h4F, 8'h01);
        chk_outs("R6 uart on");

        // R9 hold across idle and writes
        rd_chk(8'h4F, "R9 read");
        repeat (3) @(negedge clk);
        chk(bus_rdata == m_rd, "R9 hold idle", bus_rdata, m_rd);
        wr(8'h4E, 8'h07);
        chk(bus_rdata == m_rd, "R9 hold write", bus_rdata, m_rd);

        // R10 foreign address
        wr(8'h4D, 8'hAA);
        wr(8'h50, 8'h00);
        rd_chk(8'h4E, "R10 state kept");
        rd_chk(8'h10, "R10 foreign read");

        // R4 exit
        wr(8'h4E, 8'hAA);
        rd_chk(8'h4F, "R4 closed");
        wr(8'h4E, 8'h87);
        rd_chk(8'h4E, "R4 single key insufficient");

        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a, d;
            int k;
            k = $urandom_range(0, 9);
            a = (k < 5) ? 8'h4E : (k < 9) ? 8'h4F : 8'($urandom_range(0, 255));
            k = $urandom_range(0, 9);
            case (k)
                0, 1: d = 8'h87;
                2:    d = 8'hAA;
                3:    d = 8'h07;
                4:    d = 8'h30;
                5:    d = 8'hF1;
                6:    d = 8'h02;
                7:    d = 8'h08;
                default: d = 8'($urandom_range(0, 255));
            endcase
            if ($urandom_range(0, 2) == 0) rd_chk(a, "R9 random read");
            else begin
                wr(a, d);
                chk_outs("R7 random");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule